// File: doc/BRIEF.md
# Configurable Complex Mixer Crossbar

This block is the multiply-and-combine stage of a digital up/down converter. It takes four candidate receive channels, each with an in-phase and a quadrature part, one transmit sample pair, and a cosine/sine pair from an external oscillator. It produces a registered I and Q result. Four multiplier lanes (I×cos, I×sin, Q×cos, Q×sin) each choose their data operand on their own: zero, the chosen receive channel, the transmit pair with its parts swapped, or the transmit pair as it is. Each lane can also negate its product on its own. This lets one mixer serve receive mixing, transmit mixing and the split-IQ or double-rate transmit arrangements.

All routing is taken from one 16-bit configuration word, which is a plain input. Products keep full precision. The two sums saturate to the output width and are registered once.

Top module: `cmplx_mix_xbar`

## Requirements
- R1: While rst_n is low, out_i and out_q are 0.
- R2: cfg[1:0] picks the receive channel (0..3) whose parts feed the receive operand of every lane.
- R3: With cfg[2] clear the receive input is real: the Q lanes see 0 as receive data. With cfg[2] set they see the quadrature part of the chosen channel.
- R4: Operand selects sit at cfg[15:14] (I×cos), cfg[12:11] (I×sin), cfg[9:8] (Q×cos) and cfg[6:5] (Q×sin). A select of 0 makes that lane's product 0.
- R5: A select of 1 routes receive data: the in-phase part to the I lanes and the (masked, see R3) quadrature part to the Q lanes.
- R6: A select of 3 routes transmit data directly: tx_i to the I lanes and tx_q to the Q lanes.
- R7: A select of 2 routes cross-strapped transmit data: tx_q to the I lanes and tx_i to the Q lanes.
- R8: Negate flags at cfg[13] (I×cos), cfg[10] (I×sin), cfg[7] (Q×cos) and cfg[4] (Q×sin) invert the sign of that lane's 32-bit product. If the product is the most negative value, negation gives the largest positive value.
- R9: out_i equals the I×cos plus Q×sin products, and out_q equals the Q×cos plus I×sin products. Both come from the inputs present at the previous rising clock edge.
- R10: A sum above the 32-bit signed maximum gives 0x7FFFFFFF, and a sum below the minimum gives 0x80000000.
- R11: cfg[3] has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg | input | 16 | Routing and negation configuration word |
| rx_i | input | 4×16 | In-phase parts of the four receive channels, signed |
| rx_q | input | 4×16 | Quadrature parts of the four receive channels, signed |
| tx_i | input | 16 | Transmit in-phase sample, signed |
| tx_q | input | 16 | Transmit quadrature sample, signed |
| nco_cos | input | 16 | Oscillator cosine, signed |
| nco_sin | input | 16 | Oscillator sine, signed |
| out_i | output | 32 | Registered I result, signed |
| out_q | output | 32 | Registered Q result, signed |

## Verification
Each receive channel is given distinct values, so a wrong channel pick shows as a wrong number. Transmit sets tx_i and tx_q to different values, which tells the straight routing apart from the cross-strapped one. The lanes are enabled one at a time with each negate flag in turn, which exposes a misplaced field or a wrong pairing of lanes to outputs. Full-scale operands drive the sums into positive overflow and to the exact negative limit. Random words and samples, each also replayed with cfg[3] flipped, cover combinations of all modes.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
  localparam int CFG_W = 16;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_RX   = 2'd1,
    SRC_XTX  = 2'd2,
    SRC_TX   = 2'd3
  } src_e;

  typedef struct packed {
    src_e src;
    logic neg;
  } lane_cfg_t;

  // lane order: 0 I*cos, 1 I*sin, 2 Q*cos, 3 Q*sin
  function automatic lane_cfg_t lane_field(input logic [CFG_W-1:0] cfg, input int lane);
    lane_cfg_t r;
    int base;
    base  = 13 - 3 * lane;
    r.neg = cfg[base];
    r.src = src_e'(cfg[base+1 +: 2]);
    return r;
  endfunction
endpackage

// File: rtl/mxb_rx_sel.sv
module mxb_rx_sel #(
  parameter int DW = 16,
  parameter int CH = 4,
  localparam int SW = $clog2(CH)
) (
  input  logic [SW-1:0]       ch,
  input  logic                cplx,
  input  logic [CH-1:0][DW-1:0] rx_i,
  input  logic [CH-1:0][DW-1:0] rx_q,
  output logic [DW-1:0]       sel_i,
  output logic [DW-1:0]       sel_q
);
  always_comb begin
    sel_i = rx_i[ch];
    sel_q = cplx ? rx_q[ch] : '0;
  end
endmodule

// File: rtl/mxb_lane.sv
module mxb_lane
  import mxb_pkg::*;
#(
  parameter int DW    = 16,
  parameter bit Q_LANE = 1'b0,
  localparam int PW   = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lane_cfg_t     lcfg,
  input  logic [DW-1:0] rx_d,
  input  logic [DW-1:0] tx_i,
  input  logic [DW-1:0] tx_q,
  input  logic [DW-1:0] osc,
  output logic [PW-1:0] prod
);
  localparam logic [PW-1:0] P_MIN = {1'b1, {(PW-1){1'b0}}};
  localparam logic [PW-1:0] P_MAX = {1'b0, {(PW-1){1'b1}}};

  function automatic logic [PW-1:0] smul(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic signed [PW-1:0] ea, eb;
    ea = PW'($signed(a));
    eb = PW'($signed(b));
    return PW'(ea * eb);
  endfunction

  function automatic logic [PW-1:0] neg_sat(input logic [PW-1:0] p);
    if (p == P_MIN) return P_MAX;
    return PW'(-$signed(p));
  endfunction

  logic [DW-1:0] own_tx, cross_tx, opnd;
  logic [PW-1:0] raw;

  assign own_tx   = Q_LANE ? tx_q : tx_i;
  assign cross_tx = Q_LANE ? tx_i : tx_q;

  always_comb begin
    case (lcfg.src)
      SRC_RX:  opnd = rx_d;
      SRC_XTX: opnd = cross_tx;
      SRC_TX:  opnd = own_tx;
      default: opnd = '0;
    endcase
  end

  assign raw  = smul(opnd, osc);
  assign prod = lcfg.neg ? neg_sat(raw) : raw;

  p_zero_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lcfg.src == SRC_ZERO) |-> (prod == '0));

  p_neg_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lcfg.neg && raw != P_MIN) |-> ($signed(prod) == -$signed(raw)));

  p_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcfg.neg) |-> (prod == raw));
endmodule

// File: rtl/cmplx_mix_xbar.sv
module cmplx_mix_xbar
  import mxb_pkg::*;
#(
  parameter int DW = 16,
  parameter int CH = 4,
  localparam int PW = 2 * DW,
  localparam int SW = $clog2(CH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CFG_W-1:0]      cfg,
  input  logic [CH-1:0][DW-1:0] rx_i,
  input  logic [CH-1:0][DW-1:0] rx_q,
  input  logic [DW-1:0]         tx_i,
  input  logic [DW-1:0]         tx_q,
  input  logic [DW-1:0]         nco_cos,
  input  logic [DW-1:0]         nco_sin,
  output logic [PW-1:0]         out_i,
  output logic [PW-1:0]         out_q
);
  localparam logic [PW-1:0] S_MAX = {1'b0, {(PW-1){1'b1}}};
  localparam logic [PW-1:0] S_MIN = {1'b1, {(PW-1){1'b0}}};

  function automatic logic [PW:0] wide_add(input logic [PW-1:0] a, input logic [PW-1:0] b);
    return {a[PW-1], a} + {b[PW-1], b};
  endfunction

  function automatic logic [PW-1:0] clamp(input logic [PW:0] s);
    if (s[PW] != s[PW-1]) return s[PW] ? S_MIN : S_MAX;
    return s[PW-1:0];
  endfunction

  logic          unused_rsvd;
  assign unused_rsvd = cfg[3];

  logic [DW-1:0] rx_sel_i, rx_sel_q;
  logic [PW-1:0] lane_prod [LANES];

  mxb_rx_sel #(.DW(DW), .CH(CH)) u_rx_sel (
    .ch    (cfg[SW-1:0]),
    .cplx  (cfg[2]),
    .rx_i  (rx_i),
    .rx_q  (rx_q),
    .sel_i (rx_sel_i),
    .sel_q (rx_sel_q)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam bit IS_Q   = (l >= 2);
    localparam bit IS_SIN = (l % 2) == 1;
    lane_cfg_t lc;
    assign lc = lane_field(cfg, l);
    mxb_lane #(.DW(DW), .Q_LANE(IS_Q)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .lcfg (lc),
      .rx_d (IS_Q ? rx_sel_q : rx_sel_i),
      .tx_i (tx_i),
      .tx_q (tx_q),
      .osc  (IS_SIN ? nco_sin : nco_cos),
      .prod (lane_prod[l])
    );
  end

  // sums and overflow events
  logic [PW:0] sum_i_w, sum_q_w;
  logic        i_ovf_pos, i_ovf_neg, q_ovf_pos, q_ovf_neg;

  assign sum_i_w   = wide_add(lane_prod[0], lane_prod[3]);
  assign sum_q_w   = wide_add(lane_prod[2], lane_prod[1]);
  assign i_ovf_pos = !sum_i_w[PW] && sum_i_w[PW-1];
  assign i_ovf_neg = sum_i_w[PW] && !sum_i_w[PW-1];
  assign q_ovf_pos = !sum_q_w[PW] && sum_q_w[PW-1];
  assign q_ovf_neg = sum_q_w[PW] && !sum_q_w[PW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_i <= '0;
      out_q <= '0;
    end else begin
      out_i <= clamp(sum_i_w);
      out_q <= clamp(sum_q_w);
    end
  end

  p_sum_i_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(i_ovf_pos || i_ovf_neg) |=> (out_i == $past(PW'(lane_prod[0] + lane_prod[3]))));

  p_sum_q_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_ovf_pos || q_ovf_neg) |=> (out_q == $past(PW'(lane_prod[2] + lane_prod[1]))));

  p_sat_pos_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (i_ovf_pos || (q_ovf_pos && !q_ovf_neg && 1'b1 && i_ovf_pos)) |=> (out_i == S_MAX));

  p_sat_qpos_r10: assert property (@(posedge clk) disable iff (!rst_n)
    q_ovf_pos |=> (out_q == S_MAX));

  p_sat_neg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (i_ovf_neg || q_ovf_neg) |=> (out_i[PW-1] || out_q[PW-1]));

  p_real_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[2] && g_lane[2].lc.src == SRC_RX) |-> (lane_prod[2] == '0));
endmodule

// File: tb/test_cmplx_mix_xbar.sv
`timescale 1ns/1ps
module test_cmplx_mix_xbar;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cfg = '0;
  logic [3:0][15:0] rx_i = '0, rx_q = '0;
  logic [15:0] tx_i = '0, tx_q = '0, nco_cos = '0, nco_sin = '0;
  logic [31:0] out_i, out_q;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] ei; logic [31:0] eq; string tag; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  cmplx_mix_xbar i_cmplx_mix_xbar (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .rx_i(rx_i), .rx_q(rx_q),
    .tx_i(tx_i), .tx_q(tx_q), .nco_cos(nco_cos), .nco_sin(nco_sin),
    .out_i(out_i), .out_q(out_q)
  );

  function automatic longint sx(input logic [15:0] v);
    return longint'($signed(v));
  endfunction

  // lane 0 I*cos, 1 I*sin, 2 Q*cos, 3 Q*sin
  function automatic longint model_lane(input int lane, input logic [15:0] c);
    logic [1:0] s; logic n; longint d, o, p;
    case (lane)
      0: begin s = c[15:14]; n = c[13]; end
      1: begin s = c[12:11]; n = c[10]; end
      2: begin s = c[9:8];   n = c[7];  end
      default: begin s = c[6:5]; n = c[4]; end
    endcase
    o = (lane == 1 || lane == 3) ? sx(nco_sin) : sx(nco_cos);
    if (lane < 2) begin
      case (s)
        2'd1: d = sx(rx_i[c[1:0]]);
        2'd2: d = sx(tx_q);
        2'd3: d = sx(tx_i);
        default: d = 0;
      endcase
    end else begin
      case (s)
        2'd1: d = c[2] ? sx(rx_q[c[1:0]]) : 0;
        2'd2: d = sx(tx_i);
        2'd3: d = sx(tx_q);
        default: d = 0;
      endcase
    end
    p = d * o;
    if (n) p = -p;
    if (p > 64'sd2147483647) p = 64'sd2147483647;
    return p;
  endfunction

  function automatic logic [31:0] sat32(input longint v);
    if (v > 64'sd2147483647) return 32'h7FFF_FFFF;
    if (v < -64'sd2147483648) return 32'h8000_0000;
    return v[31:0];
  endfunction

  task automatic drive(input logic [15:0] c, input string tag);
    exp_t e;
    @(negedge clk);
    cfg = c;
    e.ei = sat32(model_lane(0, c) + model_lane(3, c));
    e.eq = sat32(model_lane(2, c) + model_lane(1, c));
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic set_rx();
    for (int k = 0; k < 4; k++) begin
      rx_i[k] = 16'(100 * (k + 1) + 7);
      rx_q[k] = 16'(-(50 * (k + 1) + 3));
    end
  endtask

  // monitor: one result per cycle, one register of latency (R9)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_run++;
        if (out_i !== e.ei || out_q !== e.eq) begin
          n_fail++;
          $display("FAIL %s: out_i=%0d out_q=%0d expected %0d %0d", e.tag,
                   $signed(out_i), $signed(out_q), $signed(e.ei), $signed(e.eq));
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] c;
    set_rx();
    tx_i = 16'sd1234; tx_q = -16'sd321;
    nco_cos = 16'sd300; nco_sin = -16'sd17;
    cfg = 16'hFFFF;
    repeat (3) @(negedge clk);
    n_run++;
    if (out_i !== 32'd0 || out_q !== 32'd0) begin
      n_fail++;
      $display("FAIL R1: reset out_i=%0d out_q=%0d expected 0 0", out_i, out_q);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R5: every channel, receive on all lanes, complex
    for (int ch = 0; ch < 4; ch++)
      drive({2'd1,1'b0,2'd1,1'b0,2'd1,1'b0,2'd1,1'b0,1'b0,1'b1,2'(ch)}, "R2 R5 channel pick");
    // R3: real receive masks Q lanes
    for (int ch = 0; ch < 4; ch++)
      drive({2'd1,1'b0,2'd1,1'b0,2'd1,1'b0,2'd1,1'b0,1'b0,1'b0,2'(ch)}, "R3 real receive");
    // R4: all zero selects, and each lane alone
    drive(16'h0007, "R4 all zero");
    drive(16'b01_0_00_0_00_0_00_0_0_1_10, "R4 I*cos only");
    drive(16'b00_0_01_0_00_0_00_0_0_1_10, "R4 I*sin only");
    drive(16'b00_0_00_0_01_0_00_0_0_1_10, "R4 Q*cos only");
    drive(16'b00_0_00_0_00_0_01_0_0_1_10, "R4 Q*sin only");
    // R6 / R7 transmit routing
    drive({2'd3,1'b0,2'd3,1'b0,2'd3,1'b0,2'd3,1'b0,1'b0,1'b1,2'd0}, "R6 transmit direct");
    drive({2'd2,1'b0,2'd2,1'b0,2'd2,1'b0,2'd2,1'b0,1'b0,1'b1,2'd0}, "R7 transmit cross");
    drive({2'd3,1'b0,2'd0,1'b0,2'd0,1'b0,2'd2,1'b0,1'b0,1'b1,2'd0}, "R6 R7 mixed I");
    // R8: each negate flag alone
    drive({2'd3,1'b1,2'd3,1'b0,2'd3,1'b0,2'd3,1'b0,1'b0,1'b1,2'd0}, "R8 negate I*cos");
    drive({2'd3,1'b0,2'd3,1'b1,2'd3,1'b0,2'd3,1'b0,1'b0,1'b1,2'd0}, "R8 negate I*sin");
    drive({2'd3,1'b0,2'd3,1'b0,2'd3,1'b1,2'd3,1'b0,1'b0,1'b1,2'd0}, "R8 negate Q*cos");
    drive({2'd3,1'b0,2'd3,1'b0,2'd3,1'b0,2'd3,1'b1,1'b0,1'b1,2'd0}, "R8 negate Q*sin");

    // R10: full-scale operands
    @(negedge clk);
    tx_i = 16'h8000; tx_q = 16'h8000; nco_cos = 16'h8000; nco_sin = 16'h8000;
    drive({2'd3,1'b0,2'd3,1'b0,2'd3,1'b0,2'd3,1'b0,1'b0,1'b1,2'd0}, "R10 positive saturation");
    drive({2'd3,1'b1,2'd3,1'b1,2'd3,1'b1,2'd3,1'b1,1'b0,1'b1,2'd0}, "R10 R8 negative limit");
    drive({2'd3,1'b0,2'd3,1'b1,2'd3,1'b0,2'd3,1'b1,1'b0,1'b1,2'd0}, "R10 R8 mixed sign");

    // R11 and random mixes: each word also replayed with cfg[3] flipped
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        rx_i[k] = 16'($urandom); rx_q[k] = 16'($urandom);
      end
      tx_i = 16'($urandom); tx_q = 16'($urandom);
      nco_cos = 16'($urandom); nco_sin = 16'($urandom);
      c = 16'($urandom);
      drive(c, "R9 random mix");
      drive(c ^ 16'h0008, "R11 reserved bit flipped");
    end

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule